// File: doc/BRIEF.md
# Multi-Bank Phase-Offset Clock Divider

This block produces five synchronous output clocks (four general banks and one feedback bank) from a single fast clock. One fast-clock period is the time unit of the block. A three-level range code sets how many fast cycles make one nominal period: 64, 32 or 16. Each bank divides that nominal period by its own ratio, keeps a 50% duty cycle, and shifts its edges by a signed number of time units chosen by three-level select codes.

The first two banks take a pair of selects that step evenly from −4 to +4 units. The next two banks use a wider, uneven map that reaches ±8 units, and two of its codes copy the offset of bank 1 or bank 2. The feedback bank has one select with three offsets. Bank 3 (index 2) can also be complemented. Each bank has a disable input. While it is high, the bank raises a high-impedance flag, and the clock keeps its phase underneath.

All settings are taken only at a global alignment boundary, where every bank counter restarts together. The first boundary is the first clock edge after reset, and later boundaries come every 120·N fast cycles. Because of this, edges hold a fixed offset from the common reference instant.

Top module: `phase_bank_clkgen`

## Requirements
- R1: The range code sets N, the number of fast cycles per nominal period: code 0 gives 64, code 1 gives 32, code 2 gives 16, and code 3 is treated like code 1.
- R2: A three-level select is a 2-bit code where 0 is LOW, 1 is MID, 2 is HIGH, and 3 acts as MID. For a pair of selects, the combination index is 3·hi + lo.
- R3: For banks 1 and 2, combination indices 0 to 8 give offsets −4, −3, −2, −1, 0, +1, +2, +3 and +4 time units.
- R4: For banks 3 and 4, indices 0 to 8 give −8, −7, −6, the offset of bank 1, 0, the offset of bank 2, +6, +7 and +8 time units.
- R5: The feedback phase select maps LOW, MID and HIGH to −4, 0 and +4 time units.
- R6: The 4-bit divide index values 0 to 8 select ratios 1, 2, 3, 4, 5, 6, 8, 10 and 12. Index values 9 to 15 select ratio 1. A bank's period is N times its ratio.
- R7: Let k be the number of clock edges after a boundary edge, with the boundary edge itself as k = 0. Let P be the bank period and d its offset. After edge k, the bank clock is high exactly when ((k − d) mod P) < P/2.
- R8: Range, divide, phase and invert inputs take effect only at a boundary edge. Boundaries come every 120·N cycles, with N taken from the previous boundary. Changes made between boundaries have no effect on the outputs.
- R9: A bank's high-impedance flag equals its disable input as sampled at the previous clock edge. Disabling a bank does not change its clock phase.
- R10: When the invert input is 1 at a boundary, the clock of bank 3 (index 2) is complemented until the next boundary. No other bank is affected.
- R11: While reset is asserted, all clocks are low and all high-impedance flags are high. The first clock edge after reset is a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; one period is one time unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rangeSel | input | 2 | Three-level range code that selects N |
| divSel | input | 4x4 | Divide index per general bank |
| phaseHi | input | 4x2 | More significant phase select per general bank |
| phaseLo | input | 4x2 | Less significant phase select per general bank |
| fbDiv | input | 4 | Divide index of the feedback bank |
| fbPhase | input | 2 | Phase select of the feedback bank |
| invSel | input | 1 | Complement request for bank 3 |
| bankDis | input | 4 | Disable per general bank |
| fbDis | input | 1 | Disable of the feedback bank |
| bankClk | output | 4 | General bank clocks |
| fbClk | output | 1 | Feedback bank clock |
| bankHiZ | output | 4 | High-impedance flag per general bank |
| fbHiZ | output | 1 | High-impedance flag of the feedback bank |

## Verification
At the boundary edge, two things happen in the same cycle: the counters preload with new settings, and the counters wrap naturally with the old ones. The bench changes every setting halfway through a super-period and then checks that each output still follows the old settings until the boundary. From that edge on, each output must follow the new settings, with the edge positions the bench computes. Disable toggles are also driven while the clocks run, so the flag updates coincide with clock edges and boundaries. The bench checks that the flags follow with one cycle of lag and that the clock phase does not move.

// File: rtl/phase_bank_pkg.sv
package phase_bank_pkg;

  localparam int NMAX      = 64;
  localparam int DMAX      = 12;
  localparam int SUPER_MUL = 120;
  localparam int CW        = $clog2(NMAX * DMAX + 1);
  localparam int SW        = $clog2(NMAX * SUPER_MUL + 1);

  typedef logic signed [4:0] offT;

  typedef struct packed {
    logic       ld;
    logic       run;
    logic [6:0] nNext;
  } strobeT;

  function automatic logic [1:0] lvl(input logic [1:0] c);
    return (c == 2'd3) ? 2'd1 : c;
  endfunction

  function automatic logic [3:0] comboIdx(input logic [1:0] hi, input logic [1:0] lo);
    return ({2'b00, lvl(hi)} * 4'd3) + {2'b00, lvl(lo)};
  endfunction

  function automatic logic [6:0] multOf(input logic [1:0] rng);
    case (lvl(rng))
      2'd0:    return 7'd64;
      2'd2:    return 7'd16;
      default: return 7'd32;
    endcase
  endfunction

  function automatic logic [3:0] divOf(input logic [3:0] idx);
    case (idx)
      4'd0:    return 4'd1;
      4'd1:    return 4'd2;
      4'd2:    return 4'd3;
      4'd3:    return 4'd4;
      4'd4:    return 4'd5;
      4'd5:    return 4'd6;
      4'd6:    return 4'd8;
      4'd7:    return 4'd10;
      4'd8:    return 4'd12;
      default: return 4'd1;
    endcase
  endfunction

  function automatic offT narrowOff(input logic [3:0] idx);
    case (idx)
      4'd0:    return -5'sd4;
      4'd1:    return -5'sd3;
      4'd2:    return -5'sd2;
      4'd3:    return -5'sd1;
      4'd5:    return 5'sd1;
      4'd6:    return 5'sd2;
      4'd7:    return 5'sd3;
      4'd8:    return 5'sd4;
      default: return 5'sd0;
    endcase
  endfunction

  function automatic offT wideOff(input logic [3:0] idx, input offT f1, input offT f2);
    case (idx)
      4'd0:    return -5'sd8;
      4'd1:    return -5'sd7;
      4'd2:    return -5'sd6;
      4'd3:    return f1;
      4'd5:    return f2;
      4'd6:    return 5'sd6;
      4'd7:    return 5'sd7;
      4'd8:    return 5'sd8;
      default: return 5'sd0;
    endcase
  endfunction

  function automatic offT fbOff(input logic [1:0] c);
    case (lvl(c))
      2'd0:    return -5'sd4;
      2'd2:    return 5'sd4;
      default: return 5'sd0;
    endcase
  endfunction

endpackage

// File: rtl/phase_bank_ctrl.sv
module phase_bank_ctrl
  import phase_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rangeSel,
  output strobeT     st
);

  logic          started;
  logic [SW-1:0] glbCnt;
  logic [6:0]    nCur;
  logic [SW-1:0] superLast;
  logic          boundary;

  assign superLast = (SW'(nCur) * SW'(SUPER_MUL)) - SW'(1);
  assign boundary  = !started || (glbCnt == superLast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      glbCnt  <= '0;
      nCur    <= 7'd64;
    end else if (boundary) begin
      started <= 1'b1;
      glbCnt  <= '0;
      nCur    <= multOf(rangeSel);
    end else begin
      glbCnt  <= glbCnt + SW'(1);
    end
  end

  assign st.ld    = boundary;
  assign st.run   = started;
  assign st.nNext = multOf(rangeSel);

  // R1: the latched multiplier is always one of the three legal values
  a_r1_mult_legal: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> (nCur == 7'd16 || nCur == 7'd32 || nCur == 7'd64));

  // R8: between boundaries the global counter only advances by one
  a_r8_glb_step: assert property (@(posedge clk) disable iff (!rst_n)
    (started && glbCnt != superLast) |=> (glbCnt == $past(glbCnt) + SW'(1)));

  // R8: a boundary always restarts the global counter
  a_r8_glb_restart: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (glbCnt == '0));

endmodule

// File: rtl/phase_bank_slice.sv
module phase_bank_slice
  import phase_bank_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  strobeT     st,
  input  logic [3:0] divIdx,
  input  offT        off,
  input  logic       invEn,
  input  logic       dis,
  output logic       clkOut,
  output logic       hiZ
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] per;
  logic          invQ;
  logic [CW-1:0] perNew;
  logic [CW-1:0] startV;
  logic [4:0]    negOff;

  assign perNew = CW'(st.nNext) * CW'(divOf(divIdx));
  assign negOff = 5'(-off);
  assign startV = (off <= 5'sd0) ? CW'(negOff) : (perNew - CW'(off));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      per  <= CW'(16);
      invQ <= 1'b0;
      hiZ  <= 1'b1;
    end else begin
      hiZ <= dis;
      if (st.ld) begin
        per  <= perNew;
        cnt  <= startV;
        invQ <= invEn;
      end else if (st.run) begin
        cnt <= (cnt == per - CW'(1)) ? '0 : cnt + CW'(1);
      end
    end
  end

  assign clkOut = st.run & ((cnt < (per >> 1)) ^ invQ);

  // R7: the phase counter stays inside the bank period
  a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    st.run |-> (cnt < per));

  // R7: the counter wraps to zero after the last count of a period
  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st.run && !st.ld && cnt == per - CW'(1)) |=> (cnt == '0));

  // R8: period and invert hold between boundaries
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st.run && !st.ld) |=> ($stable(per) && $stable(invQ)));

  // R9: a disable held over two edges leaves the flag raised
  a_r9_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    (dis && $past(dis)) |-> hiZ);

endmodule

// File: rtl/phase_bank_path.sv
module phase_bank_path
  import phase_bank_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int INV_BANK = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  strobeT                st,
  input  logic [NBANK-1:0][3:0] divSel,
  input  logic [NBANK-1:0][1:0] phaseHi,
  input  logic [NBANK-1:0][1:0] phaseLo,
  input  logic [3:0]            fbDiv,
  input  logic [1:0]            fbPhase,
  input  logic                  invSel,
  input  logic [NBANK-1:0]      bankDis,
  input  logic                  fbDis,
  output logic [NBANK-1:0]      bankClk,
  output logic                  fbClk,
  output logic [NBANK-1:0]      bankHiZ,
  output logic                  fbHiZ
);

  localparam int NARROW = NBANK / 2;

  offT offArr [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [3:0] idx;
    logic       invEn;
    assign idx = comboIdx(phaseHi[b], phaseLo[b]);

    if (b < NARROW) begin : g_narrow
      assign offArr[b] = narrowOff(idx);
    end else begin : g_wide
      assign offArr[b] = wideOff(idx, offArr[0], offArr[1]);
    end

    if (b == INV_BANK) begin : g_inv
      assign invEn = invSel;
    end else begin : g_noinv
      assign invEn = 1'b0;
    end

    phase_bank_slice u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .st     (st),
      .divIdx (divSel[b]),
      .off    (offArr[b]),
      .invEn  (invEn),
      .dis    (bankDis[b]),
      .clkOut (bankClk[b]),
      .hiZ    (bankHiZ[b])
    );
  end

  phase_bank_slice u_fb (
    .clk    (clk),
    .rst_n  (rst_n),
    .st     (st),
    .divIdx (fbDiv),
    .off    (fbOff(fbPhase)),
    .invEn  (1'b0),
    .dis    (fbDis),
    .clkOut (fbClk),
    .hiZ    (fbHiZ)
  );

endmodule

// File: rtl/phase_bank_clkgen.sv
module phase_bank_clkgen
  import phase_bank_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int INV_BANK = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            rangeSel,
  input  logic [NBANK-1:0][3:0] divSel,
  input  logic [NBANK-1:0][1:0] phaseHi,
  input  logic [NBANK-1:0][1:0] phaseLo,
  input  logic [3:0]            fbDiv,
  input  logic [1:0]            fbPhase,
  input  logic                  invSel,
  input  logic [NBANK-1:0]      bankDis,
  input  logic                  fbDis,
  output logic [NBANK-1:0]      bankClk,
  output logic                  fbClk,
  output logic [NBANK-1:0]      bankHiZ,
  output logic                  fbHiZ
);

  strobeT st;

  phase_bank_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rangeSel (rangeSel),
    .st       (st)
  );

  phase_bank_path #(.NBANK(NBANK), .INV_BANK(INV_BANK)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .divSel  (divSel),
    .phaseHi (phaseHi),
    .phaseLo (phaseLo),
    .fbDiv   (fbDiv),
    .fbPhase (fbPhase),
    .invSel  (invSel),
    .bankDis (bankDis),
    .fbDis   (fbDis),
    .bankClk (bankClk),
    .fbClk   (fbClk),
    .bankHiZ (bankHiZ),
    .fbHiZ   (fbHiZ)
  );

endmodule

// File: tb/phase_bank_clkgen_test.sv
module phase_bank_clkgen_test;

  typedef struct packed {
    logic [1:0]      rng;
    logic [4:0][3:0] div;
    logic [3:0][1:0] hi;
    logic [3:0][1:0] lo;
    logic [1:0]      fbPh;
    logic            inv;
    logic            mid;
    logic            dis;
  } vecT;

  localparam int NV = 5;
  localparam vecT VEC [NV] = '{
    '{2'd2, {4'd4, 4'd3, 4'd2, 4'd1, 4'd0}, {2'd1, 2'd1, 2'd2, 2'd0}, {2'd2, 2'd0, 2'd2, 2'd0}, 2'd0, 1'b0, 1'b0, 1'b0},
    '{2'd1, {4'd8, 4'd7, 4'd6, 4'd5, 4'd4}, {2'd2, 2'd0, 2'd0, 2'd1}, {2'd2, 2'd0, 2'd2, 2'd1}, 2'd2, 1'b1, 1'b1, 1'b0},
    '{2'd0, {4'd12, 4'd0, 4'd15, 4'd9, 4'd8}, {2'd0, 2'd2, 2'd2, 2'd3}, {2'd1, 2'd0, 2'd1, 2'd0}, 2'd3, 1'b0, 1'b0, 1'b1},
    '{2'd3, {4'd0, 4'd1, 4'd7, 4'd5, 4'd2}, {2'd1, 2'd1, 2'd1, 2'd0}, {2'd2, 2'd0, 2'd2, 2'd1}, 2'd1, 1'b1, 1'b0, 1'b1},
    '{2'd2, {4'd2, 4'd8, 4'd8, 4'd6, 4'd6}, {2'd2, 2'd0, 2'd3, 2'd2}, {2'd1, 2'd2, 2'd3, 2'd0}, 2'd0, 1'b0, 1'b0, 1'b0}
  };

  localparam int DIVS   [9] = '{1, 2, 3, 4, 5, 6, 8, 10, 12};
  localparam int NARROW [9] = '{-4, -3, -2, -1, 0, 1, 2, 3, 4};
  localparam int WIDE   [9] = '{-8, -7, -6, 99, 0, 98, 6, 7, 8};
  localparam int FBO    [3] = '{-4, 0, 4};

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [1:0]      rangeSel = '0;
  logic [3:0][3:0] divSel = '0;
  logic [3:0][1:0] phaseHi = '0;
  logic [3:0][1:0] phaseLo = '0;
  logic [3:0]      fbDiv = '0;
  logic [1:0]      fbPhase = '0;
  logic            invSel = 1'b0;
  logic [3:0]      bankDis = '0;
  logic            fbDis = 1'b0;
  logic [3:0]      bankClk;
  logic            fbClk;
  logic [3:0]      bankHiZ;
  logic            fbHiZ;

  int total = 0;
  int bad = 0;

  phase_bank_clkgen uut (
    .clk(clk), .rst_n(rst_n), .rangeSel(rangeSel), .divSel(divSel),
    .phaseHi(phaseHi), .phaseLo(phaseLo), .fbDiv(fbDiv), .fbPhase(fbPhase),
    .invSel(invSel), .bankDis(bankDis), .fbDis(fbDis), .bankClk(bankClk),
    .fbClk(fbClk), .bankHiZ(bankHiZ), .fbHiZ(fbHiZ)
  );

  always #5 clk = ~clk;

  function automatic int lvlB(input logic [1:0] c);
    return (c == 2'd3) ? 1 : int'(c);
  endfunction

  function automatic int multB(input logic [1:0] r);
    int l = lvlB(r);
    return (l == 0) ? 64 : (l == 1) ? 32 : 16;
  endfunction

  function automatic int divB(input logic [3:0] i);
    return (i <= 4'd8) ? DIVS[i] : 1;
  endfunction

  // offset of bank b (4 = feedback) for vector v, per R2..R5
  function automatic int offB(input int v, input int b);
    int idx;
    int w;
    if (b == 4) return FBO[lvlB(VEC[v].fbPh)];
    idx = 3 * lvlB(VEC[v].hi[b]) + lvlB(VEC[v].lo[b]);
    if (b < 2) return NARROW[idx];
    w = WIDE[idx];
    if (w == 99) return offB(v, 0);
    if (w == 98) return offB(v, 1);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic applyCfg(input int v);
    rangeSel = VEC[v].rng;
    for (int b = 0; b < 4; b++) divSel[b] = VEC[v].div[b];
    fbDiv    = VEC[v].div[4];
    phaseHi  = VEC[v].hi;
    phaseLo  = VEC[v].lo;
    fbPhase  = VEC[v].fbPh;
    invSel   = VEC[v].inv;
  endtask

  // Applies vector v, waits for the boundary, checks one full super-period
  task automatic runVec(input int v);
    int n;
    int s;
    int per [5];
    int off [5];
    int errs [5];
    int firstK [5];
    int firstA [5];
    int hzErr;
    logic [4:0] prevDis;
    logic [4:0] curDis;
    logic [4:0] act;
    applyCfg(v);
    bankDis = '0;
    fbDis   = 1'b0;
    n = multB(VEC[v].rng);
    s = n * 120;
    for (int b = 0; b < 5; b++) begin
      per[b] = n * divB(VEC[v].div[b]);
      off[b] = offB(v, b);
      errs[b] = 0;
      firstK[b] = -1;
      firstA[b] = 0;
    end
    hzErr = 0;
    prevDis = '0;
    @(posedge clk);
    for (int k = 0; k < s; k++) begin
      @(negedge clk);
      act = {fbClk, bankClk};
      for (int b = 0; b < 5; b++) begin
        int ph;
        bit e;
        ph = ((k - off[b]) % per[b] + per[b]) % per[b];
        e = (ph < per[b] / 2);
        if (b == 2 && VEC[v].inv) e = !e;
        if (act[b] !== e) begin
          if (errs[b] == 0) begin
            firstK[b] = k;
            firstA[b] = int'(act[b]);
          end
          errs[b]++;
        end
      end
      if (k > 0 && {fbHiZ, bankHiZ} !== prevDis) hzErr++;
      curDis = VEC[v].dis ? 5'(k >> 3) : 5'd0;
      bankDis = curDis[3:0];
      fbDis   = curDis[4];
      prevDis = curDis;
      if (VEC[v].mid && k == s / 2) applyCfg((v + 1) % NV);
    end
    for (int b = 0; b < 5; b++) begin
      string req;
      req = (b < 2) ? "R3/R7" : (b < 4) ? "R4/R7" : "R5/R7";
      if (b == 2 && VEC[v].inv) req = "R10/R4";
      if (VEC[v].mid) req = {req, "/R8"};
      check(errs[b] == 0, req,
            $sformatf("vec %0d bank %0d mismatches, first k=%0d value", v, b, firstK[b]),
            firstA[b], (firstK[b] < 0) ? firstA[b] : 1 - firstA[b]);
    end
    check(hzErr == 0, "R9", $sformatf("vec %0d hiZ flag mismatch cycles", v), hzErr, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    applyCfg(0);
    repeat (3) @(negedge clk);
    // R11: reset state
    check({fbClk, bankClk} == 5'd0, "R11", "clocks in reset", int'({fbClk, bankClk}), 0);
    check({fbHiZ, bankHiZ} == 5'h1f, "R11", "hiZ flags in reset", int'({fbHiZ, bankHiZ}), 31);
    rst_n = 1'b1;
    // vector walk: R1, R2, R6 via range/select/divide codes in the table
    for (int v = 0; v < NV; v++) runVec(v);
    // R11: reset in the middle of a run
    repeat (37) @(negedge clk);
    rst_n = 1'b0;
    bankDis = 4'b0000;
    #1;
    check({fbClk, bankClk} == 5'd0, "R11", "clocks after mid-run reset", int'({fbClk, bankClk}), 0);
    check({fbHiZ, bankHiZ} == 5'h1f, "R11", "hiZ after mid-run reset", int'({fbHiZ, bankHiZ}), 31);
    @(negedge clk);
    check({fbClk, bankClk} == 5'd0, "R11", "clocks held in reset", int'({fbClk, bankClk}), 0);
    rst_n = 1'b1;
    // R11: first edge after release is a boundary; R6 invalid indices again
    runVec(2);
    runVec(0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule